// File: doc/BRIEF.md
# HDMI Audio Clock Regeneration Calculator

This block turns a video pixel clock, given in kHz, into the three N/CTS pairs that an HDMI source advertises so a sink can rebuild the audio sample clock. It produces a pair for each of the 32 kHz, 44.1 kHz and 48 kHz sample rates. Common video clocks are served from a fixed table in a single cycle. Any other clock falls back to an arithmetic path. For each rate that path reduces the fraction 128·fs / (clock·1000) to lowest terms with a binary GCD. It then scales both terms by the smallest integer that brings N to at least 128·fs/1000, and flags results where N falls outside the recommended window.

A caller pulses `start` with `pclk_khz` valid and waits for the one-cycle `done` pulse. The results stay on the outputs until a later accepted start. The arithmetic path shares one restoring divider across its three divisions and takes several hundred cycles.

Top module: `acr_calc`

## Requirements
- R1: During and after reset, with no start yet accepted, every N, CTS and flag output is zero and both busy and done are low.
- R2: A start that arrives while idle, with a pixel clock of 25175, 25200, 27000, 27027, 54000, 54054, 74176, 74250, 148352 or 148500 kHz, is a table hit. N for 32 kHz becomes 4096 and N for 48 kHz becomes 6144, and both CTS values equal the clock. Done pulses in the first cycle after the start edge, busy stays low, and all flags are cleared.
- R3: On a table hit, the 44.1 kHz pair is N=5733 for 74176 and 148352 kHz, with CTS 75335 and 150670 respectively. It is N=28224 with CTS 125875 for 25175 kHz. For every other table clock it is N=6272 with CTS equal to clock·10/9.
- R4: On a table miss, each rate fs in {32000, 44100, 48000} starts from N0=128·fs and C0=clock·1000. Both are divided by gcd(N0, C0), giving Nr and Cr.
- R5: The miss result is N = Nr·m and CTS = Cr·m, where m = floor((T + Nr − 1) / Nr) and T = floor(128·fs/1000). So N is the smallest multiple of Nr not below T.
- R6: Bit 0, bit 1 and bit 2 of `n_low` and `n_high` belong to 32 kHz, 44.1 kHz and 48 kHz. A low bit is set when the final N is below floor(128·fs/1500). A high bit is set when N is above floor(128·fs/300). Both bits are cleared on a table hit.
- R7: On a miss, busy is high from the cycle after the start edge until done. Done is a single-cycle pulse during which busy is low.
- R8: A start that arrives while busy is ignored, and the results belong to the clock accepted first.
- R9: While idle with no start, every N, CTS and flag output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| pclk_khz | input | CLKW | Pixel clock in kHz, sampled with an accepted start |
| busy | output | 1 | Arithmetic path in progress |
| done | output | 1 | One-cycle completion pulse |
| n32 | output | W | N for 32 kHz |
| cts32 | output | W | CTS for 32 kHz |
| n44 | output | W | N for 44.1 kHz |
| cts44 | output | W | CTS for 44.1 kHz |
| n48 | output | W | N for 48 kHz |
| cts48 | output | W | CTS for 48 kHz |
| n_low | output | 3 | Per-rate flag, N below the recommended window |
| n_high | output | 3 | Per-rate flag, N above the recommended window |

## Verification
The assertions assume that the pixel clock is small enough for clock·1000 to fit in W bits, and that start is a plain level sampled at the clock edge. The minimum-N property also relies on every result coming either from the table or from the rounding step. The stimulus keeps to clocks below 2^18. It drives start as isolated one-cycle pulses, apart from a deliberate pulse during busy, and sweeps every table clock together with a dense range of tiny clocks. Tiny clocks give fractions with very small GCDs, and those push the 44.1 kHz N above the high limit.

// File: rtl/acr_calc.sv
module acr_calc #(
  parameter int CLKW = 18,
  parameter int W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CLKW-1:0] pclk_khz,
  output logic            busy,
  output logic            done,
  output logic [W-1:0]    n32,
  output logic [W-1:0]    cts32,
  output logic [W-1:0]    n44,
  output logic [W-1:0]    cts44,
  output logic [W-1:0]    n48,
  output logic [W-1:0]    cts48,
  output logic [2:0]      n_low,
  output logic [2:0]      n_high
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [2:0] {S_IDLE, S_GCD, S_DN, S_DC, S_DM} st_t;
  st_t st;

  function automatic int fs_of(input logic [1:0] i);
    return (i == 2'd0) ? 32000 : (i == 2'd1) ? 44100 : 48000;
  endfunction
  function automatic logic [W-1:0] n0_of(input logic [1:0] i);
    return W'(128 * fs_of(i));
  endfunction
  function automatic logic [W-1:0] tgt_of(input logic [1:0] i);
    return W'(128 * fs_of(i) / 1000);
  endfunction
  function automatic logic [W-1:0] lo_of(input logic [1:0] i);
    return W'(128 * fs_of(i) / 1500);
  endfunction
  function automatic logic [W-1:0] hi_of(input logic [1:0] i);
    return W'(128 * fs_of(i) / 300);
  endfunction

  logic [1:0]      idx;
  logic [CLKW-1:0] pclk_q;
  logic [W-1:0]    ga, gb, g, nred, ctsr;
  logic [CW-1:0]   gk;
  logic [W-1:0]    dq, dd, dr;
  logic [CW-1:0]   dcnt;
  logic [W-1:0]    nq [3];
  logic [W-1:0]    cq [3];

  // table lookup
  logic         hit;
  logic [W-1:0] t_n44, t_c44;
  always_comb begin
    hit   = 1'b1;
    t_n44 = W'(6272);
    t_c44 = '0;
    case (int'(pclk_khz))
      25175:  begin t_n44 = W'(28224); t_c44 = W'(125875); end
      25200:  t_c44 = W'(28000);
      27000:  t_c44 = W'(30000);
      27027:  t_c44 = W'(30030);
      54000:  t_c44 = W'(60000);
      54054:  t_c44 = W'(60060);
      74176:  begin t_n44 = W'(5733); t_c44 = W'(75335); end
      74250:  t_c44 = W'(82500);
      148352: begin t_n44 = W'(5733); t_c44 = W'(150670); end
      148500: t_c44 = W'(165000);
      default: hit = 1'b0;
    endcase
  end

  // shared datapath wires
  logic [W-1:0] cts0, gres, nf, cf;
  logic [W:0]   dr_sh, dsub;
  assign cts0  = W'(pclk_q) * W'(1000);
  assign gres  = (ga | gb) << gk;
  assign dr_sh = {dr, dq[W-1]};
  assign dsub  = dr_sh - {1'b0, dd};
  assign nf    = nred * dq;
  assign cf    = ctsr * dq;

  assign busy   = (st != S_IDLE);
  assign n32    = nq[0];
  assign cts32  = cq[0];
  assign n44    = nq[1];
  assign cts44  = cq[1];
  assign n48    = nq[2];
  assign cts48  = cq[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      idx    <= '0;
      pclk_q <= '0;
      ga     <= '0;
      gb     <= '0;
      gk     <= '0;
      g      <= '0;
      nred   <= '0;
      ctsr   <= '0;
      dq     <= '0;
      dd     <= '0;
      dr     <= '0;
      dcnt   <= '0;
      n_low  <= '0;
      n_high <= '0;
      for (int i = 0; i < 3; i++) begin
        nq[i] <= '0;
        cq[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (st != S_IDLE && st != S_GCD && dcnt != '0) begin
        dr   <= dsub[W] ? dr_sh[W-1:0] : dsub[W-1:0];
        dq   <= {dq[W-2:0], ~dsub[W]};
        dcnt <= dcnt - 1'b1;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            if (hit) begin
              nq[0]  <= W'(4096);
              cq[0]  <= W'(pclk_khz);
              nq[1]  <= t_n44;
              cq[1]  <= t_c44;
              nq[2]  <= W'(6144);
              cq[2]  <= W'(pclk_khz);
              n_low  <= '0;
              n_high <= '0;
              done   <= 1'b1;
            end else begin
              pclk_q <= pclk_khz;
              idx    <= '0;
              ga     <= n0_of(2'd0);
              gb     <= W'(pclk_khz) * W'(1000);
              gk     <= '0;
              st     <= S_GCD;
            end
          end
          S_GCD: begin
            if (ga == '0 || gb == '0) begin
              g    <= gres;
              dq   <= n0_of(idx);
              dd   <= gres;
              dr   <= '0;
              dcnt <= CW'(W);
              st   <= S_DN;
            end else if (!ga[0] && !gb[0]) begin
              ga <= ga >> 1;
              gb <= gb >> 1;
              gk <= gk + 1'b1;
            end else if (!ga[0]) begin
              ga <= ga >> 1;
            end else if (!gb[0]) begin
              gb <= gb >> 1;
            end else if (ga >= gb) begin
              ga <= ga - gb;
            end else begin
              gb <= gb - ga;
            end
          end
          S_DN: begin
            nred <= dq;
            dq   <= cts0;
            dd   <= g;
            dr   <= '0;
            dcnt <= CW'(W);
            st   <= S_DC;
          end
          S_DC: begin
            ctsr <= dq;
            dq   <= tgt_of(idx) + nred - W'(1);
            dd   <= nred;
            dr   <= '0;
            dcnt <= CW'(W);
            st   <= S_DM;
          end
          S_DM: begin
            nq[idx]     <= nf;
            cq[idx]     <= cf;
            n_low[idx]  <= (nf < lo_of(idx));
            n_high[idx] <= (nf > hi_of(idx));
            if (idx == 2'd2) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              idx <= idx + 2'd1;
              ga  <= n0_of(idx + 2'd1);
              gb  <= cts0;
              gk  <= '0;
              st  <= S_GCD;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/acr_calc_chk.sv
module acr_calc_chk #(
  parameter int CLKW = 18,
  parameter int W    = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] n32,
  input logic [W-1:0] cts32,
  input logic [W-1:0] n44,
  input logic [W-1:0] cts44,
  input logic [W-1:0] n48,
  input logic [W-1:0] cts48,
  input logic [2:0]   n_low,
  input logic [2:0]   n_high
);
  localparam logic [W-1:0] T32 = W'(128 * 32000 / 1000);
  localparam logic [W-1:0] T44 = W'(128 * 44100 / 1000);
  localparam logic [W-1:0] T48 = W'(128 * 48000 / 1000);

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done);

  a_r7_start_acts: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy || done);

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable({n32, cts32, n44, cts44, n48, cts48, n_low, n_high}));

  a_r5_n_not_below_target: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (n32 >= T32) && (n44 >= T44) && (n48 >= T48));
endmodule

bind acr_calc acr_calc_chk #(.CLKW(CLKW), .W(W)) u_chk (.*);

// File: tb/tb_acr_calc.sv
module tb_acr_calc;
  localparam int CLKW = 18;
  localparam int W    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CLKW-1:0] pclk_khz = '0;
  logic busy, done;
  logic [W-1:0] n32, cts32, n44, cts44, n48, cts48;
  logic [2:0] n_low, n_high;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  acr_calc #(.CLKW(CLKW), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pclk_khz(pclk_khz),
    .busy(busy), .done(done),
    .n32(n32), .cts32(cts32), .n44(n44), .cts44(cts44), .n48(n48), .cts48(cts48),
    .n_low(n_low), .n_high(n_high));

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint gcd_e(input longint a, input longint b);
    longint t;
    while (b != 0) begin
      t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  function automatic bit tab44(input int c, output longint n, output longint ct);
    n = 6272;
    ct = longint'(c) * 10 / 9;
    case (c)
      25175: begin n = 28224; ct = 125875; end
      74176: begin n = 5733; ct = 75335; end
      148352: begin n = 5733; ct = 150670; end
      25200, 27000, 27027, 54000, 54054, 74250, 148500: ;
      default: return 1'b0;
    endcase
    return 1'b1;
  endfunction

  task automatic expect_rate(input int c, input int f, output longint n, output longint ct,
                             output bit lo, output bit hi);
    longint g, t, m;
    n = 128 * longint'(f);
    ct = longint'(c) * 1000;
    g = gcd_e(n, ct);
    n = n / g;
    ct = ct / g;
    t = (128 * longint'(f)) / 1000;
    m = (t + n - 1) / n;
    n = n * m;
    ct = ct * m;
    lo = (n < (128 * longint'(f)) / 1500);
    hi = (n > (128 * longint'(f)) / 300);
  endtask

  task automatic pulse(input int c);
    @(negedge clk);
    start = 1'b1;
    pclk_khz = CLKW'(c);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_results(input int c);
    longint en, ec, dn, dc;
    bit lo, hi;
    int fsl [3];
    fsl = '{32000, 44100, 48000};
    if (tab44(c, dn, dc)) begin
      chk("R2 n32", n32, 4096);
      chk("R2 cts32", cts32, c);
      chk("R2 n48", n48, 6144);
      chk("R2 cts48", cts48, c);
      chk("R3 n44", n44, dn);
      chk("R3 cts44", cts44, dc);
      chk("R6 flags clear on hit", {n_low, n_high}, 0);
    end else begin
      for (int r = 0; r < 3; r++) begin
        expect_rate(c, fsl[r], en, ec, lo, hi);
        chk("R4 R5 n", (r == 0) ? n32 : (r == 1) ? n44 : n48, en);
        chk("R4 R5 cts", (r == 0) ? cts32 : (r == 1) ? cts44 : cts48, ec);
        chk("R6 low flag", n_low[r], lo);
        chk("R6 high flag", n_high[r], hi);
      end
    end
  endtask

  task automatic run_one(input int c);
    int cyc;
    longint dn, dc;
    bit is_hit;
    is_hit = tab44(c, dn, dc);
    pulse(c);
    if (is_hit) begin
      chk("R2 done after one cycle", done, 1);
      chk("R2 busy low on hit", busy, 0);
    end else begin
      chk("R7 busy after start", busy, 1);
      chk("R7 done low while busy", done, 0);
    end
    wait_done(cyc);
    chk("R7 done reached", done, 1);
    chk("R7 busy low with done", busy, 0);
    check_results(c);
    @(negedge clk);
    chk("R7 done single cycle", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R7 actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [W-1:0] s32, s44, s48;
    int tclk [10];
    int mclk [9];
    tclk = '{25175, 25200, 27000, 27027, 54000, 54054, 74176, 74250, 148352, 148500};
    mclk = '{0, 25000, 25176, 65000, 100000, 108000, 148351, 162000, 262143};

    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs zero", n32 | cts32 | n44 | cts44 | n48 | cts48, 0);
    chk("R1 flags zero", {n_low, n_high}, 0);
    chk("R1 idle", {busy, done}, 0);

    foreach (tclk[i]) run_one(tclk[i]);
    for (int c = 1; c <= 40; c++) run_one(c);
    foreach (mclk[i]) run_one(mclk[i]);

    // R8: start while busy ignored
    pulse(65000);
    repeat (5) @(negedge clk);
    pulse(74250);
    chk("R8 still busy after second start", busy, 1);
    wait_done(cyc);
    check_results(65000);
    chk("R8 n32 from first clock", n32 == 32'd4096 && cts32 == 32'd74250, 0);

    // R9: hold while idle, input changes
    s32 = n32; s44 = n44; s48 = n48;
    pclk_khz = CLKW'(27000);
    repeat (20) @(negedge clk);
    chk("R9 n32 held", n32, s32);
    chk("R9 n44 held", n44, s44);
    chk("R9 n48 held", n48, s48);
    check_results(65000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule